// File: doc/BRIEF.md
# Speculation ID Allocator with Periodic Scrub Reclaim

This block manages a fixed pool of speculation identifiers that a memory system hands to transactions as they begin. A requester raises `alloc_req` and receives, in the same cycle, the lowest-numbered identifier that is currently free. The identifier becomes active at the next clock edge. When no identifier is free, the grant is withheld and the requester keeps asking until one comes back.

Ending a transaction does not return its identifier. A commit or an invalidate command moves an active identifier into one of two pending states. A scrub engine starts a pass at a programmable interval and probes every identifier in turn, one per cycle. The cache answers each probe with a flag that says whether any line still refers to that identifier. A pending identifier with no remaining lines is freed when it is probed. An identifier with lines still present waits for a later pass. Commands aimed at an identifier that is not active are dropped and raise a sticky error flag. A registered count of free identifiers is kept alongside the pool.

Top module: `specid_alloc`

## Requirements
- R1: After reset, all NUM_IDS (default 128) identifiers are free, `free_count` equals NUM_IDS, `cmd_err` is 0, `scrub_active` is 0 and the scrub interval is 132 cycles.
- R2: While `alloc_req` is high and some identifier is free, `alloc_gnt` is high in the same cycle and `alloc_id` is the lowest-numbered free identifier. That identifier is active from the next edge.
- R3: With no free identifier, `alloc_gnt` stays low while `alloc_req` is held. The first grant after a reclaim carries the reclaimed identifier.
- R4: A command with `cmd_valid` high on an active identifier moves it to pending (`cmd_kind` 0 = commit, 1 = invalidate). It is not granted again and does not count as free until a scrub pass reclaims it.
- R5: A pending identifier is freed at the edge where it is probed with `line_refs` low. If `line_refs` is high at its probe, it stays pending until a later pass.
- R6: A command on an identifier that is free or already pending changes no state, and it sets `cmd_err`, which stays high until reset.
- R7: A scrub pass holds `scrub_active` high for NUM_IDS cycles and presents `scrub_id` = 0, 1, … NUM_IDS-1, one per cycle. Passes start every interval cycles, counted start to start, when the interval is longer than a pass.
- R8: A `cfg_wr` pulse loads `cfg_interval` as the new scrub interval. The spacing between pass starts that follow uses the new value.
- R9: `free_count` drops by one at each grant, rises by one at each reclaim, and always equals the number of free identifiers.
- R10: Committed and invalidated identifiers are both reclaimed by the same scrub rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Request for a new identifier |
| alloc_gnt | output | 1 | Grant, same cycle as the request |
| alloc_id | output | 7 | Granted identifier |
| cmd_valid | input | 1 | Command strobe |
| cmd_kind | input | 1 | 0 commit, 1 invalidate |
| cmd_id | input | 7 | Command target identifier |
| scrub_active | output | 1 | Scrub pass in progress |
| scrub_id | output | 7 | Identifier probed this cycle |
| line_refs | input | 1 | Lines still refer to `scrub_id` |
| cfg_wr | input | 1 | Load the scrub interval |
| cfg_interval | input | 16 | New scrub interval in cycles |
| free_count | output | 8 | Number of free identifiers |
| cmd_err | output | 1 | Sticky flag for illegal commands |

## Verification
The hardest situation to reach from the ports is pool exhaustion followed by a reclaim. The bench holds `alloc_req` until all identifiers are granted and `free_count` reaches zero. It then commits one identifier while the request is still pending, so the stalled requester must receive exactly that identifier once the next scrub pass reaches it. A second hard case is an identifier that lines keep alive. The bench answers `line_refs` from its own table indexed by `scrub_id`, so it can pin one invalidated identifier through a whole pass and then release it on the next.

// File: rtl/specid_pkg.sv
package specid_pkg;
  typedef enum logic [1:0] {
    ST_FREE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_COMMIT = 2'd2,
    ST_INVAL  = 2'd3
  } id_state_e;

  localparam logic KIND_COMMIT = 1'b0;
  localparam logic KIND_INVAL  = 1'b1;
endpackage

// File: rtl/specid_pick.sv
module specid_pick #(
  parameter int N  = 128,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  free_vec,
  output logic          any_free,
  output logic [IW-1:0] low_idx
);
  // lowest set bit wins
  always_comb begin
    any_free = 1'b0;
    low_idx  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_vec[i]) begin
        any_free = 1'b1;
        low_idx  = IW'(i);
      end
    end
  end
endmodule

// File: rtl/specid_scrub.sv
module specid_scrub #(
  parameter int N           = 128,
  parameter int IW          = $clog2(N),
  parameter int TW          = 16,
  parameter int DEF_INTERVAL = 132
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr,
  input  logic [TW-1:0] cfg_interval,
  output logic          active,
  output logic [IW-1:0] ptr
);
  localparam logic [IW-1:0] LAST_ID = IW'(N - 1);

  logic [TW-1:0] interval_q;
  logic [TW-1:0] timer_q;
  logic          start;

  // a pass begins once the interval has elapsed and the previous pass is done
  assign start = !active && ({1'b0, timer_q} + 1'b1 >= {1'b0, interval_q});

  always_ff @(posedge clk) begin
    if (rst) begin
      interval_q <= TW'(DEF_INTERVAL);
      timer_q    <= '0;
      active     <= 1'b0;
      ptr        <= '0;
    end else begin
      if (cfg_wr) interval_q <= cfg_interval;
      if (start) begin
        timer_q <= '0;
        active  <= 1'b1;
        ptr     <= '0;
      end else begin
        if (timer_q != '1) timer_q <= timer_q + 1'b1;
        if (active) begin
          if (ptr == LAST_ID) begin
            active <= 1'b0;
            ptr    <= '0;
          end else begin
            ptr <= ptr + 1'b1;
          end
        end
      end
    end
  end

  // R7: the probe walks upward by one each cycle of a pass
  a_r7_walk_step: assert property (@(posedge clk) disable iff (rst)
    (active && $past(active)) |-> (ptr == $past(ptr) + 1'b1));

  // R7: a pass always begins at identifier zero
  a_r7_pass_from_zero: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> (ptr == '0));
endmodule

// File: rtl/specid_table.sv
module specid_table
  import specid_pkg::*;
#(
  parameter int N  = 128,
  parameter int IW = $clog2(N),
  parameter int CW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          gnt_en,
  input  logic [IW-1:0] gnt_id,
  input  logic          cmd_valid,
  input  logic          cmd_kind,
  input  logic [IW-1:0] cmd_id,
  input  logic          scrub_en,
  input  logic [IW-1:0] scrub_id,
  input  logic          scrub_busy,
  output logic [N-1:0]  free_vec,
  output logic [CW-1:0] free_count,
  output logic          cmd_err
);
  id_state_e st_q [N];
  logic      cmd_ok;
  logic      reclaim;

  assign cmd_ok  = cmd_valid && (st_q[cmd_id] == ST_ACTIVE);
  assign reclaim = scrub_en && !scrub_busy &&
                   ((st_q[scrub_id] == ST_COMMIT) || (st_q[scrub_id] == ST_INVAL));

  for (genvar i = 0; i < N; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        st_q[i] <= ST_FREE;
      end else if (gnt_en && gnt_id == IW'(i)) begin
        st_q[i] <= ST_ACTIVE;
      end else if (cmd_ok && cmd_id == IW'(i)) begin
        st_q[i] <= (cmd_kind == KIND_INVAL) ? ST_INVAL : ST_COMMIT;
      end else if (reclaim && scrub_id == IW'(i)) begin
        st_q[i] <= ST_FREE;
      end
    end
    assign free_vec[i] = (st_q[i] == ST_FREE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      free_count <= CW'(N);
      cmd_err    <= 1'b0;
    end else begin
      free_count <= free_count - CW'(gnt_en) + CW'(reclaim);
      if (cmd_valid && !cmd_ok) cmd_err <= 1'b1;
    end
  end

  // R6: error flag never drops without reset
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
    cmd_err |=> cmd_err);

  // R5: a probe that finds lines still present frees nothing
  a_r5_busy_holds: assert property (@(posedge clk) disable iff (rst)
    (scrub_en && scrub_busy) |=> (free_count <= $past(free_count)));

  // R9: the count never exceeds the pool
  a_r9_count_range: assert property (@(posedge clk) disable iff (rst)
    free_count <= CW'(N));
endmodule

// File: rtl/specid_alloc.sv
module specid_alloc
  import specid_pkg::*;
#(
  parameter int NUM_IDS      = 128,
  parameter int TW           = 16,
  parameter int DEF_INTERVAL = 132,
  localparam int IW = $clog2(NUM_IDS),
  localparam int CW = $clog2(NUM_IDS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc_req,
  output logic          alloc_gnt,
  output logic [IW-1:0] alloc_id,
  input  logic          cmd_valid,
  input  logic          cmd_kind,
  input  logic [IW-1:0] cmd_id,
  output logic          scrub_active,
  output logic [IW-1:0] scrub_id,
  input  logic          line_refs,
  input  logic          cfg_wr,
  input  logic [TW-1:0] cfg_interval,
  output logic [CW-1:0] free_count,
  output logic          cmd_err
);
  logic [NUM_IDS-1:0] free_vec;
  logic               any_free;

  specid_pick #(.N(NUM_IDS), .IW(IW)) u_pick (
    .free_vec (free_vec),
    .any_free (any_free),
    .low_idx  (alloc_id)
  );

  assign alloc_gnt = alloc_req && any_free;

  specid_scrub #(.N(NUM_IDS), .IW(IW), .TW(TW), .DEF_INTERVAL(DEF_INTERVAL)) u_scrub (
    .clk          (clk),
    .rst          (rst),
    .cfg_wr       (cfg_wr),
    .cfg_interval (cfg_interval),
    .active       (scrub_active),
    .ptr          (scrub_id)
  );

  specid_table #(.N(NUM_IDS), .IW(IW), .CW(CW)) u_table (
    .clk        (clk),
    .rst        (rst),
    .gnt_en     (alloc_gnt),
    .gnt_id     (alloc_id),
    .cmd_valid  (cmd_valid),
    .cmd_kind   (cmd_kind),
    .cmd_id     (cmd_id),
    .scrub_en   (scrub_active),
    .scrub_id   (scrub_id),
    .scrub_busy (line_refs),
    .free_vec   (free_vec),
    .free_count (free_count),
    .cmd_err    (cmd_err)
  );

  // R3: no grant when the registered count says the pool is empty
  a_r3_no_grant_empty: assert property (@(posedge clk) disable iff (rst)
    alloc_gnt |-> (free_count != '0));

  // R2: the granted identifier is one that the table holds as free
  a_r2_grant_is_free: assert property (@(posedge clk) disable iff (rst)
    alloc_gnt |-> free_vec[alloc_id]);

  // R9: registered count agrees with the per-entry state
  a_r9_count_matches: assert property (@(posedge clk) disable iff (rst)
    free_count == CW'($countones(free_vec)));
endmodule

// File: tb/specid_alloc_test.sv
module specid_alloc_test;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 128;
  localparam int IW = 7;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          alloc_req = 1'b0;
  logic          alloc_gnt;
  logic [IW-1:0] alloc_id;
  logic          cmd_valid = 1'b0;
  logic          cmd_kind = 1'b0;
  logic [IW-1:0] cmd_id = '0;
  logic          scrub_active;
  logic [IW-1:0] scrub_id;
  logic          line_refs;
  logic          cfg_wr = 1'b0;
  logic [15:0]   cfg_interval = '0;
  logic [CW-1:0] free_count;
  logic          cmd_err;
  logic [N-1:0]  busy = '0;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign line_refs = busy[scrub_id];

  specid_alloc uut (
    .clk(clk), .rst(rst), .alloc_req(alloc_req), .alloc_gnt(alloc_gnt),
    .alloc_id(alloc_id), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_id(cmd_id), .scrub_active(scrub_active), .scrub_id(scrub_id),
    .line_refs(line_refs), .cfg_wr(cfg_wr), .cfg_interval(cfg_interval),
    .free_count(free_count), .cmd_err(cmd_err)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic grant_one(input int exp_id, input string req);
    @(negedge clk);
    alloc_req = 1'b1;
    #1;
    check({req, " grant"}, int'(alloc_gnt), 1);
    check({req, " lowest id"}, int'(alloc_id), exp_id);
    @(posedge clk);
    #1 alloc_req = 1'b0;
  endtask

  task automatic send_cmd(input logic kind, input int id);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_kind  = kind;
    cmd_id    = IW'(id);
    @(posedge clk);
    #1 cmd_valid = 1'b0;
  endtask

  task automatic wait_pass();
    int n = 0;
    do begin @(negedge clk); n++; end while (!scrub_active && n < 1000);
    do begin @(negedge clk); n++; end while (scrub_active && n < 2000);
  endtask

  // returns cycles between two consecutive pass starts, and pass length
  task automatic measure(output int spacing, output int len);
    logic prev;
    int   n = 0;
    prev = 1'b1;
    do begin prev = scrub_active; @(negedge clk); n++; end
      while (!(scrub_active && !prev) && n < 1000);
    len = 0; spacing = 0;
    do begin
      prev = scrub_active;
      @(negedge clk);
      spacing++;
      if (prev) len++;
    end while (!(scrub_active && !prev) && spacing < 1000);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 free_count", int'(free_count), N);
    check("R1 cmd_err", int'(cmd_err), 0);
    check("R1 scrub_active", int'(scrub_active), 0);
    check("R1 no grant idle", int'(alloc_gnt), 0);
  endtask

  task automatic t_grant_basic();
    grant_one(0, "R2");
    grant_one(1, "R2");
    grant_one(2, "R2");
    @(negedge clk);
    check("R9 count after grants", int'(free_count), N - 3);
  endtask

  task automatic t_pending();
    send_cmd(1'b0, 1);
    send_cmd(1'b1, 2);
    @(negedge clk);
    check("R4 valid cmds no error", int'(cmd_err), 0);
    check("R4 pending not free", int'(free_count), N - 3);
    busy[2] = 1'b1;
    grant_one(3, "R4 pending skipped");
    wait_pass();
    check("R5 busy id held, other reclaimed", int'(free_count), N - 3);
    grant_one(1, "R5 committed id reused");
    grant_one(4, "R5 busy id still pending");
    busy[2] = 1'b0;
    wait_pass();
    check("R10 invalidated reclaimed", int'(free_count), N - 4);
    grant_one(2, "R10 invalidated id reused");
  endtask

  task automatic t_bad_cmd();
    send_cmd(1'b0, 100);
    @(negedge clk);
    check("R6 err on free id", int'(cmd_err), 1);
    check("R6 free id untouched", int'(free_count), N - 5);
    grant_one(5, "R6 lowest free unchanged");
    send_cmd(1'b0, 5);
    send_cmd(1'b1, 5);
    wait_pass();
    check("R6 double cmd reclaims once", int'(free_count), N - 5);
    check("R6 err sticky", int'(cmd_err), 1);
    grant_one(5, "R6 id back after pass");
  endtask

  task automatic t_interval();
    int sp, ln;
    measure(sp, ln);
    check("R7 default spacing", sp, 132);
    check("R7 pass length", ln, N);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_interval = 16'd200;
    @(posedge clk);
    #1 cfg_wr = 1'b0;
    measure(sp, ln);
    check("R8 programmed spacing", sp, 200);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_interval = 16'd140;
    @(posedge clk);
    #1 cfg_wr = 1'b0;
  endtask

  task automatic t_exhaust();
    int n = 0;
    int got = -1;
    @(negedge clk);
    alloc_req = 1'b1;
    do begin @(negedge clk); n++; end while (free_count != 0 && n < 300);
    #1;
    check("R3 pool empty", int'(free_count), 0);
    check("R3 no grant when empty", int'(alloc_gnt), 0);
    send_cmd(1'b0, 7);
    n = 0;
    while (got < 0 && n < 600) begin
      @(negedge clk); n++;
      #1;
      if (alloc_gnt) got = int'(alloc_id);
    end
    check("R3 stalled request gets reclaimed id", got, 7);
    @(posedge clk);
    #1 alloc_req = 1'b0;
    @(negedge clk);
    check("R9 count back to zero", int'(free_count), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_grant_basic();
    t_pending();
    t_bad_cmd();
    t_interval();
    t_exhaust();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule